// File: doc/BRIEF.md
# Interrupt Source Router

This block gathers a set of level-sensitive interrupt request inputs and steers each one onto one of several output interrupt lines. Software sets it up through a small 32-bit register port that holds an enable mask, a read-only view of the source levels, and a bank of routing words that hold one 4-bit selector for each source.

Each source input is first brought into the clock domain by a two-flop synchroniser. A source is pending while its synchronised level and its enable bit are both 1. Output line j is driven high while at least one pending source has a selector equal to j+1. A selector of zero leaves its source attached to nothing. The outputs come from registers, so they follow the mask, the routing and the synchronised levels with one clock of delay.

Top module: `irq_route_ctrl`

## Requirements
- R1: After synchronous reset the enable mask and all four routing words read as 0, and every bit of `irq_o` is 0.
- R2: The enable mask is read/write at byte offset 0x00. Bit n of the mask enables source n.
- R3: Offset 0x04 is read-only. It returns the source input levels delayed by two clocks, regardless of the mask. Writes to it change nothing.
- R4: The routing words are read/write at offsets 0x08, 0x0C, 0x10 and 0x14. Sources 0–7 sit in 0x14, 8–15 in 0x10, 16–23 in 0x0C and 24–31 in 0x08. Source k uses bits [4*(k mod 8)+3 : 4*(k mod 8)] of its word.
- R5: A source whose routing selector is 0 drives no output line, even when it is enabled and high.
- R6: A selector value v from 1 to 15 sends its pending source to output line v-1 and to no other line.
- R7: A source whose mask bit is 0 drives no output line, even while its level shows in the 0x04 register.
- R8: An output line stays high while any pending source routed to it is high, and it falls only when the last such source goes low.
- R9: `irq_o` changes exactly one clock after a mask or routing write takes effect. A source level change reaches `irq_o` after three clocks.
- R10: Reads from any other offset, including offsets that are not 4-byte aligned, return 0. Writes to such offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Raw level-sensitive interrupt sources |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 15 | Routed output interrupt lines |

## Verification
The hardest case to reach from the ports is several enabled sources sharing one line. The line must stay high while the sources drop away one at a time and fall only after the last one. The bench routes sources from three different routing words to the same selector and then clears their input levels one by one. This also shows that the reversed word order is decoded the same way in every word. A second hard case is one-cycle output timing. The bench samples `irq_o` on the falling edge right after a mask write and again one clock later.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned DW        = 32;
    localparam int unsigned FIELD_W   = 4;
    localparam int unsigned PER_WORD  = DW / FIELD_W;

    localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_STAT   = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_ROUTE0 = 8'h08;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_MASK,
        SEL_STAT,
        SEL_ROUTE
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e          sel;
        logic [ADDR_W-1:0] idx;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int unsigned n_route);
        reg_dec_t d;
        logic [ADDR_W-1:0] rel;
        d.sel = SEL_NONE;
        d.idx = '0;
        rel   = a - OFF_ROUTE0;
        if (a[1:0] == 2'b00) begin
            if (a == OFF_MASK) begin
                d.sel = SEL_MASK;
            end else if (a == OFF_STAT) begin
                d.sel = SEL_STAT;
            end else if (a >= OFF_ROUTE0 &&
                         int'(rel) < 4 * int'(n_route)) begin
                d.sel = SEL_ROUTE;
                d.idx = rel >> 2;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] pipe;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                pipe[g] <= '0;
            end else if (g == 0) begin
                pipe[g] <= d_i;
            end else begin
                pipe[g] <= pipe[(g == 0) ? 0 : g - 1];
            end
        end
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_route_pkg::*;
#(
    parameter int unsigned N_SRC   = 32,
    parameter int unsigned N_ROUTE = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic                        we_i,
    input  logic [DW-1:0]               wdata_i,
    input  logic [N_SRC-1:0]            status_i,
    output logic [DW-1:0]               rdata_o,
    output logic [N_SRC-1:0]            mask_o,
    output logic [N_ROUTE-1:0][DW-1:0]  route_o
);
    reg_dec_t dec;
    assign dec = decode_addr(addr_i, N_ROUTE);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_o <= '0;
        end else if (we_i && dec.sel == SEL_MASK) begin
            mask_o <= wdata_i[N_SRC-1:0];
        end
    end

    for (genvar r = 0; r < N_ROUTE; r++) begin : g_route
        always_ff @(posedge clk) begin
            if (rst) begin
                route_o[r] <= '0;
            end else if (we_i && dec.sel == SEL_ROUTE && int'(dec.idx) == r) begin
                route_o[r] <= wdata_i;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (dec.sel)
            SEL_MASK:  rdata_o = DW'(mask_o);
            SEL_STAT:  rdata_o = DW'(status_i);
            SEL_ROUTE: begin
                for (int r = 0; r < int'(N_ROUTE); r++) begin
                    if (int'(dec.idx) == r) rdata_o = route_o[r];
                end
            end
            default:   rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_route_fabric.sv
module irq_route_fabric
    import irq_route_pkg::*;
#(
    parameter int unsigned N_SRC   = 32,
    parameter int unsigned N_OUT   = 15,
    parameter int unsigned N_ROUTE = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_SRC-1:0]            pending_i,
    input  logic [N_ROUTE-1:0][DW-1:0]  route_i,
    output logic [N_OUT-1:0]            irq_o
);
    logic [N_SRC-1:0][FIELD_W-1:0] sel;
    logic [N_OUT-1:0]              hit;

    for (genvar s = 0; s < N_SRC; s++) begin : g_field
        localparam int unsigned WORD = N_ROUTE - 1 - s / PER_WORD;
        localparam int unsigned LSB  = FIELD_W * (s % PER_WORD);
        assign sel[s] = route_i[WORD][LSB +: FIELD_W];
    end

    for (genvar j = 0; j < N_OUT; j++) begin : g_line
        localparam logic [FIELD_W-1:0] CODE = FIELD_W'(j + 1);
        always_comb begin
            hit[j] = 1'b0;
            for (int s = 0; s < int'(N_SRC); s++) begin
                hit[j] = hit[j] | (pending_i[s] && sel[s] == CODE);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_o <= '0;
        else     irq_o <= hit;
    end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int unsigned N_SRC = 32,
    parameter int unsigned N_OUT = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [N_OUT-1:0]  irq_o
);
    localparam int unsigned N_ROUTE = (N_SRC * FIELD_W + DW - 1) / DW;

    logic [N_SRC-1:0]           status_q;
    logic [N_SRC-1:0]           mask_q;
    logic [N_ROUTE-1:0][DW-1:0] route_q;
    logic [N_SRC-1:0]           pending;

    irq_sync #(.W(N_SRC), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (src_i),
        .q_o (status_q)
    );

    irq_regfile #(.N_SRC(N_SRC), .N_ROUTE(N_ROUTE)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr_i   (bus_addr),
        .we_i     (bus_we),
        .wdata_i  (bus_wdata),
        .status_i (status_q),
        .rdata_o  (bus_rdata),
        .mask_o   (mask_q),
        .route_o  (route_q)
    );

    assign pending = status_q & mask_q;

    irq_route_fabric #(.N_SRC(N_SRC), .N_OUT(N_OUT), .N_ROUTE(N_ROUTE)) u_fabric (
        .clk       (clk),
        .rst       (rst),
        .pending_i (pending),
        .route_i   (route_q),
        .irq_o     (irq_o)
    );
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
    import irq_route_pkg::*;
#(
    parameter int unsigned N_SRC = 32,
    parameter int unsigned N_OUT = 15
) (
    input logic              clk,
    input logic              rst,
    input logic [N_SRC-1:0]  src_i,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DW-1:0]     bus_wdata,
    input logic [DW-1:0]     bus_rdata,
    input logic [N_OUT-1:0]  irq_o,
    input logic [N_SRC-1:0]  mask_q,
    input logic [N_SRC-1:0]  status_q
);
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)              warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (irq_o == '0));

    p_mask_write_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFF_MASK) |=> (mask_q == $past(bus_wdata[N_SRC-1:0])));

    p_status_lag_r3: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && bus_addr == OFF_STAT) |-> (bus_rdata == DW'($past(src_i, 2))));

    p_masked_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (warm != 2'd0 && $past(mask_q & status_q) == '0) |-> (irq_o == '0));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[1:0] != 2'b00 || bus_addr > 8'h14) |-> (bus_rdata == '0));
endmodule

bind irq_route_ctrl irq_route_chk #(.N_SRC(N_SRC), .N_OUT(N_OUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_i     (src_i),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .mask_q    (mask_q),
    .status_q  (status_q)
);

// File: tb/irq_route_ctrl_tb.sv
module irq_route_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src = '0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [14:0] irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] mask_m = '0;
    logic [3:0]  rte_m [32];

    always #2 clk = ~clk;

    irq_route_ctrl u_dut (
        .clk (clk), .rst (rst), .src_i (src),
        .bus_addr (addr), .bus_we (we), .bus_wdata (wdata),
        .bus_rdata (rdata), .irq_o (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] word_off(input int s);
        return 8'h08 + 8'(4 * (3 - s / 8));
    endfunction

    function automatic logic [31:0] pack_word(input int w);
        logic [31:0] v = '0;
        for (int k = 0; k < 8; k++) v[4*k +: 4] = rte_m[8 * (3 - w) + k];
        return v;
    endfunction

    function automatic logic [14:0] exp_irq();
        logic [14:0] e = '0;
        for (int s = 0; s < 32; s++)
            if (src[s] && mask_m[s] && rte_m[s] != 4'd0) e[rte_m[s] - 1] = 1'b1;
        return e;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic set_mask(input logic [31:0] m);
        mask_m = m;
        wr(8'h00, m);
    endtask

    task automatic set_route(input int s, input logic [3:0] v);
        rte_m[s] = v;
        wr(word_off(s), pack_word((word_off(s) - 8'h08) / 4));
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_all();
        for (int s = 0; s < 32; s++) rte_m[s] = '0;
        for (int w = 0; w < 4; w++) wr(8'h08 + 8'(4 * w), '0);
        set_mask('0);
        @(negedge clk); src = '0;
        settle();
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq during reset", 32'(irq), '0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        rd(8'h00, d); chk("R1 mask after reset", d, '0);
        for (int w = 0; w < 4; w++) begin
            rd(8'h08 + 8'(4 * w), d); chk("R1 route after reset", d, '0);
        end
        chk("R1 irq after reset", 32'(irq), '0);
    endtask

    task automatic t_mask_rw();
        logic [31:0] d;
        set_mask(32'hA5A5_0F0F);
        rd(8'h00, d); chk("R2 mask readback", d, 32'hA5A5_0F0F);
        set_mask(32'h0000_0000);
        rd(8'h00, d); chk("R2 mask cleared", d, '0);
    endtask

    task automatic t_status();
        logic [31:0] d;
        @(negedge clk); src = 32'h1234_5678;
        @(negedge clk);
        rd(8'h04, d); chk("R3 status one clock", d, '0);
        @(negedge clk);
        rd(8'h04, d); chk("R3 status two clocks", d, 32'h1234_5678);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, d); chk("R3 status write ignored", d, 32'h1234_5678);
        rd(8'h00, d); chk("R3 status write leaves mask", d, '0);
        chk("R7 masked sources quiet", 32'(irq), '0);
        @(negedge clk); src = '0;
        settle();
    endtask

    task automatic t_route_rw();
        logic [31:0] d;
        for (int w = 0; w < 4; w++) begin
            wr(8'h08 + 8'(4 * w), 32'h1357_9BD0 + 32'(w));
            rd(8'h08 + 8'(4 * w), d);
            chk("R4 route readback", d, 32'h1357_9BD0 + 32'(w));
        end
        clear_all();
    endtask

    task automatic t_lines();
        for (int v = 1; v <= 15; v++) begin
            int s = (v * 7) % 32;
            set_mask(32'hFFFF_FFFF);
            set_route(s, 4'(v));
            @(negedge clk); src = 32'h1 << s;
            settle();
            chk("R6 R4 selector to line", 32'(irq), 32'(exp_irq()));
            chk("R6 single line", 32'(irq), 32'h1 << (v - 1));
            set_route(s, 4'd0);
            @(negedge clk); src = '0;
            settle();
        end
        clear_all();
    endtask

    task automatic t_disconnect();
        set_mask(32'hFFFF_FFFF);
        @(negedge clk); src = 32'h0000_0008;
        settle();
        chk("R5 selector zero quiet", 32'(irq), '0);
        set_route(3, 4'd5);
        settle();
        chk("R5 selector set drives", 32'(irq), 32'h10);
        clear_all();
    endtask

    task automatic t_mask_gate();
        logic [31:0] d;
        set_route(10, 4'd2);
        @(negedge clk); src = 32'h0000_0400;
        settle();
        chk("R7 mask clear quiet", 32'(irq), '0);
        rd(8'h04, d); chk("R7 status still visible", d, 32'h0000_0400);
        set_mask(32'h0000_0400);
        settle();
        chk("R7 mask set drives", 32'(irq), 32'h2);
        clear_all();
    endtask

    task automatic t_or_share();
        set_mask(32'hFFFF_FFFF);
        set_route(0, 4'd7);
        set_route(17, 4'd7);
        set_route(31, 4'd7);
        @(negedge clk); src = 32'h8002_0001;
        settle();
        chk("R8 shared line high", 32'(irq), 32'h40);
        @(negedge clk); src = 32'h8000_0001;
        settle();
        chk("R8 two left", 32'(irq), 32'h40);
        @(negedge clk); src = 32'h8000_0000;
        settle();
        chk("R8 one left", 32'(irq), 32'h40);
        @(negedge clk); src = '0;
        settle();
        chk("R8 last gone", 32'(irq), '0);
        clear_all();
    endtask

    task automatic t_latency();
        set_route(20, 4'd15);
        @(negedge clk); src = 32'h0010_0000;
        settle();
        chk("R9 before mask", 32'(irq), '0);
        set_mask(32'h0010_0000);
        chk("R9 same cycle as write", 32'(irq), '0);
        @(negedge clk);
        chk("R9 one clock after write", 32'(irq), 32'h4000);
        src = '0;
        @(negedge clk);
        chk("R9 src drop +1", 32'(irq), 32'h4000);
        @(negedge clk);
        chk("R9 src drop +2", 32'(irq), 32'h4000);
        @(negedge clk);
        chk("R9 src drop +3", 32'(irq), '0);
        clear_all();
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        set_mask(32'h0F0F_0F0F);
        rd(8'h18, d); chk("R10 read 0x18", d, '0);
        rd(8'h02, d); chk("R10 read 0x02", d, '0);
        rd(8'hFC, d); chk("R10 read 0xFC", d, '0);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h01, 32'hFFFF_FFFF);
        wr(8'h09, 32'hFFFF_FFFF);
        rd(8'h00, d); chk("R10 mask untouched", d, 32'h0F0F_0F0F);
        for (int w = 0; w < 4; w++) begin
            rd(8'h08 + 8'(4 * w), d); chk("R10 route untouched", d, '0);
        end
        clear_all();
    endtask

    initial begin
        for (int s = 0; s < 32; s++) rte_m[s] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        t_mask_rw();
        t_status();
        t_route_rw();
        t_lines();
        t_disconnect();
        t_mask_gate();
        t_or_share();
        t_latency();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule